// File: doc/BRIEF.md
# Serial Control Port with Peak-Level Status

This block is the configuration front door of a stereo converter. A host writes three 10-bit control registers and reads two peak-level status registers over a four-wire serial link: a bit clock, an active-low select, serial data in and serial data out. Each transfer is a 16-bit command word sent MSB first. The 4-bit address sits in bits 15:12, the direction flag in bit 11 (1 = read, 0 = write) and a reserved bit in bit 10 that is ignored. The register data sits in bits 9:0. The serial pins are sampled by the block's system clock through synchronizers, so the serial bit clock must be much slower than the system clock.

The control registers drive the decoded fields straight out as ports: gain codes, filter and power controls, data format, word width, master/slave and mutes, and a master-clock divider with bypass flags for the front end. They are stored bits only. The block also watches a left and a right sample stream and keeps, per channel, the loudest level seen since that channel's status register was last read. The level is held as a 6-bit attenuation code: 0 is full scale and each step is about 1 dB quieter.

Top module: `ctl_serial_port`

## Requirements
- R1: After reset every control output is 0, including master mode (`slave_mode` = 0) and the normal modulator clock (`mod_clk_fast` = 0). `sdo` is 0, and both peak registers read back 63.
- R2: A valid write to address 0 sets, from data bits 9..0: `peak_enable` (bit 9), `hpf_enable` (8), `power_down` (7), `mod_clk_fast` (6), `gain_left` (5:3) and `gain_right` (2:0).
- R3: A valid write to address 1 sets `data_format` (bits 6:5), `word_width` (4:3), `slave_mode` (2), `mute_right` (1) and `mute_left` (0). Bits 9:7 are not stored.
- R4: A valid write to address 2 sets `bypass_right` (bit 3), `bypass_left` (bit 2) and `mclk_div` (bits 1:0). Bits 9:4 are not stored.
- R5: A read (bit 11 = 1) of address 3 (left) or 4 (right) returns the 10-bit word {4'b0, peak} on `sdo`, MSB first. Each bit is valid during the low phase of bit periods 7 to 16 of the frame; `sdo` changes only after a falling edge of `sclk`. `sdo` is 0 during the six header periods and while `sel_n` is high.
- R6: A frame whose select-low window holds any number of rising `sclk` edges other than 16 has no effect. It writes nothing, and an aborted read does not clear the peak register.
- R7: Writes to addresses 3 to 15 change no control output. Reads of any address other than 3 and 4 return all zeros on `sdo`.
- R8: A sample's code follows these rules. Let m be its magnitude (two's complement; the most negative value counts as 2^(W-1)). If m = 0 the code is 63; if m >= 2^(W-1) the code is 0. Otherwise let b be the index of the top set bit of m and let q = floor(m / 2^(b-7)) (m shifted left when b < 7), so 128 <= q <= 255. The code is min(63, 6*(W-2-b) + s), where s counts the k in 1..5 with q < 256*10^(-k/20).
- R9: Each peak register holds the smallest code among the samples captured since its last valid read. A valid read of a register resets it to 63.
- R10: Samples are captured only while `peak_enable` is 1; otherwise the peak registers do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial bit clock; data is sampled on its rising edge |
| sel_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial command data, MSB first |
| sdo | output | 1 | Serial readback data |
| smp_valid | input | 1 | Strobe: both sample inputs hold a new sample |
| smp_left | input | SAMPLE_W | Left sample, two's complement |
| smp_right | input | SAMPLE_W | Right sample, two's complement |
| peak_enable | output | 1 | Peak capture enable |
| hpf_enable | output | 1 | High-pass filter enable |
| power_down | output | 1 | Power-down request |
| mod_clk_fast | output | 1 | Modulator clock select (0 = normal rate) |
| gain_left | output | 3 | Left input gain code |
| gain_right | output | 3 | Right input gain code |
| data_format | output | 2 | Serial audio format select |
| word_width | output | 2 | Audio word width select |
| slave_mode | output | 1 | 0 = master, 1 = slave |
| mute_right | output | 1 | Right channel mute |
| mute_left | output | 1 | Left channel mute |
| mclk_div | output | 2 | Master clock divider select |
| bypass_left | output | 1 | Left front-end bypass (power-down) |
| bypass_right | output | 1 | Right front-end bypass (power-down) |

## Verification
The bench sweeps walking-one and alternating data patterns through all three control registers. A field placed one bit off, or a register that keeps bits it should drop, shows up as a mismatched output vector. It sends frames with 15 and 17 clock edges and writes to the peak addresses and to unused addresses. A design that commits on any select release, or decodes too few address bits, would corrupt a control field there. The attenuation code is swept across every magnitude octave and across mantissas on both sides of each in-octave threshold, with full-scale negative and zero samples included. An off-by-one in the octave count or a wrong threshold gives a code one or six steps away. The bench also checks that the peak holds the minimum of several samples, that a completed read clears it while an aborted read does not, and that nothing is captured while the enable is low.

// File: rtl/ctl_port_pkg.sv
// Shared constants and register layouts for the serial control port.
// Assumes 16-bit command words with a 4-bit address and 10-bit data.
package ctl_port_pkg;

    localparam int CMD_W  = 16;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 10;

    localparam logic [ADDR_W-1:0] ADR_CFG0  = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_CFG1  = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_CFG2  = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_PK_L  = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_PK_R  = 4'd4;

    // Register 0 layout, MSB is data bit 9.
    typedef struct packed {
        logic       pk_en;
        logic       hp_en;
        logic       pdn;
        logic       mod_fast;
        logic [2:0] gain_l;
        logic [2:0] gain_r;
    } cfg0_t;

    // Register 1 layout, occupies data bits 6:0.
    typedef struct packed {
        logic [1:0] fmt;
        logic [1:0] wlen;
        logic       slave;
        logic       mute_r;
        logic       mute_l;
    } cfg1_t;

    // Register 2 layout, occupies data bits 3:0.
    typedef struct packed {
        logic       byp_r;
        logic       byp_l;
        logic [1:0] mclk_div;
    } cfg2_t;

    typedef enum logic [1:0] {
        RD_NONE  = 2'd0,
        RD_LEFT  = 2'd1,
        RD_RIGHT = 2'd2
    } rd_sel_e;

endpackage

// File: rtl/bit_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes each bit is independent; reset loads RST_VAL into every stage.
module bit_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    // Shift the asynchronous inputs through the synchronizer chain.
    always_ff @(posedge clk) begin : sync_chain
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/scp_frontend.sv
// Serial front end: synchronizes the pins, detects bit-clock edges and
// shifts command bits in on rising edges while select is low.
// Assumes the bit clock half period spans several system clocks.
// The edge count saturates at CMD_W+1 so oversized frames stay invalid.
module scp_frontend #(
    parameter int CMD_W       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(CMD_W + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_i,
    input  logic             sel_n_i,
    input  logic             sdi_i,
    output logic             rise_o,
    output logic             fall_o,
    output logic             frame_end_o,
    output logic             in_frame_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CMD_W-1:0] word_o
);

    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(CMD_W + 1);

    logic [2:0]       pins_s;
    logic             clk_s, sel_s, dat_s;
    logic             clk_prv, sel_prv;
    logic [CNT_W-1:0] cnt_q;
    logic [CMD_W-1:0] word_q;

    bit_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk_i, sel_n_i, sdi_i}),
        .q     (pins_s)
    );

    assign clk_s = pins_s[2];
    assign sel_s = pins_s[1];
    assign dat_s = pins_s[0];

    // Remember last synchronized levels for edge detection.
    always_ff @(posedge clk) begin : edge_hist
        if (!rst_n) begin
            clk_prv <= 1'b0;
            sel_prv <= 1'b1;
        end else begin
            clk_prv <= clk_s;
            sel_prv <= sel_s;
        end
    end

    assign in_frame_o  = ~sel_s;
    assign rise_o      = in_frame_o & clk_s & ~clk_prv;
    assign fall_o      = in_frame_o & ~clk_s & clk_prv;
    assign frame_end_o = sel_s & ~sel_prv;

    // Clear at frame start, then shift data and count rising edges.
    always_ff @(posedge clk) begin : shift_count
        if (!rst_n) begin
            cnt_q  <= '0;
            word_q <= '0;
        end else if (~sel_s & sel_prv) begin
            cnt_q  <= '0;
            word_q <= '0;
        end else if (rise_o) begin
            word_q <= {word_q[CMD_W-2:0], dat_s};
            if (cnt_q != CNT_SAT) cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt_o  = cnt_q;
    assign word_o = word_q;

endmodule

// File: rtl/ctl_regs.sv
// Write-only control register file. Commits a write when a frame ends
// with exactly CMD_W edges, the direction flag is 0 and the address
// names one of the three control registers. Everything else is dropped.
module ctl_regs
    import ctl_port_pkg::*;
#(
    localparam int CNT_W = $clog2(CMD_W + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_end,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CMD_W-1:0] word,
    output cfg0_t            cfg0,
    output cfg1_t            cfg1,
    output cfg2_t            cfg2
);

    localparam int RW_BIT = DATA_W + 1;

    logic              commit;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;

    assign addr   = word[CMD_W-1 -: ADDR_W];
    assign data   = word[DATA_W-1:0];
    assign commit = frame_end && (cnt == CNT_W'(CMD_W)) && !word[RW_BIT];

    // Load the addressed control register on a valid write frame.
    always_ff @(posedge clk) begin : reg_write
        if (!rst_n) begin
            cfg0 <= '0;
            cfg1 <= '0;
            cfg2 <= '0;
        end else if (commit) begin
            case (addr)
                ADR_CFG0: cfg0 <= cfg0_t'(data);
                ADR_CFG1: cfg1 <= cfg1_t'(data[$bits(cfg1_t)-1:0]);
                ADR_CFG2: cfg2 <= cfg2_t'(data[$bits(cfg2_t)-1:0]);
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/peak_track.sv
// Per-channel peak hold. Converts a sample magnitude to an attenuation
// code (0 = full scale, about 1 dB per step, saturating at all ones) and
// keeps the smallest code since the last clear. Assumes SAMPLE_W >= 9.
module peak_track #(
    parameter int SAMPLE_W = 24,
    parameter int PEAK_W   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                valid,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                clr,
    output logic [PEAK_W-1:0]   peak
);

    localparam int              MANT_W  = 8;
    localparam int              STEPS   = 6;
    localparam int              PK_MAX  = (1 << PEAK_W) - 1;
    localparam logic [PEAK_W-1:0] PK_ALL = '1;

    // Magnitude to attenuation code: octave count plus in-octave step.
    function automatic logic [PEAK_W-1:0] atten_code(input logic [SAMPLE_W-1:0] mag);
        int                  msb;
        int                  sub;
        int                  code;
        logic [SAMPLE_W-1:0] norm;
        logic [MANT_W-1:0]   q;
        msb = -1;
        for (int i = 0; i < SAMPLE_W; i++) if (mag[i]) msb = i;
        if (msb < 0) return PK_ALL;
        if (msb == SAMPLE_W - 1) return '0;
        norm = mag << (SAMPLE_W - 1 - msb);
        q    = norm[SAMPLE_W-1 -: MANT_W];
        sub  = 0;
        if (q < 8'd229) sub++;
        if (q < 8'd204) sub++;
        if (q < 8'd182) sub++;
        if (q < 8'd162) sub++;
        if (q < 8'd144) sub++;
        code = STEPS * (SAMPLE_W - 2 - msb) + sub;
        if (code > PK_MAX) return PK_ALL;
        return code[PEAK_W-1:0];
    endfunction

    logic [SAMPLE_W-1:0] mag;
    logic [PEAK_W-1:0]   cand;
    logic                take;

    assign mag  = sample[SAMPLE_W-1] ? (~sample + SAMPLE_W'(1)) : sample;
    assign cand = atten_code(mag);
    assign take = en && valid;

    // Track the minimum code; a clear restarts from silence.
    always_ff @(posedge clk) begin : peak_hold
        if (!rst_n) begin
            peak <= PK_ALL;
        end else if (clr) begin
            peak <= take ? cand : PK_ALL;
        end else if (take && (cand < peak)) begin
            peak <= cand;
        end
    end

endmodule

// File: rtl/ctl_serial_port.sv
// Top level: serial control port with three write-only control registers
// and two read-only peak registers. A read loads the selected peak word
// after the six header bits and shifts it out on sdo on falling bit-clock
// edges; a read that completes with exactly CMD_W edges clears that peak.
module ctl_serial_port
    import ctl_port_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int PEAK_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk,
    input  logic                sel_n,
    input  logic                sdi,
    output logic                sdo,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    output logic                peak_enable,
    output logic                hpf_enable,
    output logic                power_down,
    output logic                mod_clk_fast,
    output logic [2:0]          gain_left,
    output logic [2:0]          gain_right,
    output logic [1:0]          data_format,
    output logic [1:0]          word_width,
    output logic                slave_mode,
    output logic                mute_right,
    output logic                mute_left,
    output logic [1:0]          mclk_div,
    output logic                bypass_left,
    output logic                bypass_right
);

    localparam int CNT_W    = $clog2(CMD_W + 2);
    localparam int HDR_BITS = CMD_W - DATA_W;
    localparam int N_CH     = 2;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_BITS);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CMD_W);

    logic             rise_ev, fall_ev, frame_end, in_frame;
    logic [CNT_W-1:0] bit_cnt;
    logic [CMD_W-1:0] cmd_word;
    cfg0_t            cfg0;
    cfg1_t            cfg1;
    cfg2_t            cfg2;

    logic [SAMPLE_W-1:0] smp_arr [N_CH];
    logic [PEAK_W-1:0]   peak_q  [N_CH];
    logic [N_CH-1:0]     clr_pk;

    rd_sel_e           rd_sel;
    logic [DATA_W-1:0] out_sr;
    logic              sdo_q;
    logic [ADDR_W-1:0] hdr_addr;
    logic              hdr_read;

    scp_frontend #(.CMD_W(CMD_W), .SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (sclk),
        .sel_n_i     (sel_n),
        .sdi_i       (sdi),
        .rise_o      (rise_ev),
        .fall_o      (fall_ev),
        .frame_end_o (frame_end),
        .in_frame_o  (in_frame),
        .cnt_o       (bit_cnt),
        .word_o      (cmd_word)
    );

    ctl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .cnt       (bit_cnt),
        .word      (cmd_word),
        .cfg0      (cfg0),
        .cfg1      (cfg1),
        .cfg2      (cfg2)
    );

    assign smp_arr[0] = smp_left;
    assign smp_arr[1] = smp_right;

    // One peak tracker per channel; its clear comes from a finished read.
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_peak
        peak_track #(.SAMPLE_W(SAMPLE_W), .PEAK_W(PEAK_W)) u_pk (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (cfg0.pk_en),
            .valid  (smp_valid),
            .sample (smp_arr[ch]),
            .clr    (clr_pk[ch]),
            .peak   (peak_q[ch])
        );
    end

    assign clr_pk[0] = frame_end && (bit_cnt == CNT_FULL) && (rd_sel == RD_LEFT);
    assign clr_pk[1] = frame_end && (bit_cnt == CNT_FULL) && (rd_sel == RD_RIGHT);

    // Header seen so far when the sixth rising edge arrives.
    assign hdr_addr = cmd_word[ADDR_W:1];
    assign hdr_read = cmd_word[0];

    // Select and load the readback word, then shift it out on falling edges.
    always_ff @(posedge clk) begin : readback
        if (!rst_n) begin
            rd_sel <= RD_NONE;
            out_sr <= '0;
            sdo_q  <= 1'b0;
        end else if (!in_frame) begin
            rd_sel <= RD_NONE;
            sdo_q  <= 1'b0;
        end else if (rise_ev && (bit_cnt == CNT_LOAD)) begin
            if (hdr_read && (hdr_addr == ADR_PK_L)) begin
                rd_sel <= RD_LEFT;
                out_sr <= {{(DATA_W-PEAK_W){1'b0}}, peak_q[0]};
            end else if (hdr_read && (hdr_addr == ADR_PK_R)) begin
                rd_sel <= RD_RIGHT;
                out_sr <= {{(DATA_W-PEAK_W){1'b0}}, peak_q[1]};
            end else begin
                rd_sel <= RD_NONE;
                out_sr <= '0;
            end
        end else if (fall_ev) begin
            if ((rd_sel != RD_NONE) && (bit_cnt >= CNT_HDR) && (bit_cnt < CNT_FULL)) begin
                sdo_q  <= out_sr[DATA_W-1];
                out_sr <= {out_sr[DATA_W-2:0], 1'b0};
            end else begin
                sdo_q  <= 1'b0;
            end
        end
    end

    assign sdo          = sdo_q;
    assign peak_enable  = cfg0.pk_en;
    assign hpf_enable   = cfg0.hp_en;
    assign power_down   = cfg0.pdn;
    assign mod_clk_fast = cfg0.mod_fast;
    assign gain_left    = cfg0.gain_l;
    assign gain_right   = cfg0.gain_r;
    assign data_format  = cfg1.fmt;
    assign word_width   = cfg1.wlen;
    assign slave_mode   = cfg1.slave;
    assign mute_right   = cfg1.mute_r;
    assign mute_left    = cfg1.mute_l;
    assign mclk_div     = cfg2.mclk_div;
    assign bypass_left  = cfg2.byp_l;
    assign bypass_right = cfg2.byp_r;

endmodule

// File: rtl/ctl_serial_port_chk.sv
// Assertion checker for ctl_serial_port, attached by bind below.
module ctl_serial_port_chk #(
    parameter int PEAK_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_end,
    input logic              fall_ev,
    input logic              sdo,
    input logic [1:0]        clr,
    input logic              smp_valid,
    input logic              pk_en,
    input logic [PEAK_W-1:0] peak_l,
    input logic [PEAK_W-1:0] peak_r,
    input logic [20:0]       cfg_all
);

    localparam logic [PEAK_W-1:0] PK_ALL = '1;

    // R6: control outputs move only in the cycle after a frame ends.
    assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(cfg_all));

    // R5: sdo changes only after a falling bit-clock edge or at frame end.
    assert_sdo_timing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall_ev && !frame_end) |=> $stable(sdo));

    // R9: without a clear a peak code never rises (never gets quieter).
    assert_peak_mono_l_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr[0]) |-> (peak_l <= $past(peak_l)));
    assert_peak_mono_r_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr[1]) |-> (peak_r <= $past(peak_r)));

    // R9: a clear with no sample returns the register to silence.
    assert_peak_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[0] && !smp_valid) |=> (peak_l == PK_ALL));

    // R10: with capture disabled and no clear the peaks stay put.
    assert_no_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pk_en && (clr == 2'b00)) |=> ($stable(peak_l) && $stable(peak_r)));

endmodule

bind ctl_serial_port ctl_serial_port_chk #(.PEAK_W(PEAK_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .fall_ev   (fall_ev),
    .sdo       (sdo),
    .clr       (clr_pk),
    .smp_valid (smp_valid),
    .pk_en     (peak_enable),
    .peak_l    (peak_q[0]),
    .peak_r    (peak_q[1]),
    .cfg_all   ({cfg0, cfg1, cfg2})
);

// File: tb/tb_ctl_serial_port.sv
// Self-checking bench: register field sweeps, frame-length and address
// corner cases, and an arithmetic sweep of the attenuation code.
module tb_ctl_serial_port;

    localparam int SW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sclk = 1'b0;
    logic          sel_n = 1'b1;
    logic          sdi = 1'b0;
    logic          smp_valid = 1'b0;
    logic [SW-1:0] smp_left = '0;
    logic [SW-1:0] smp_right = '0;
    logic          sdo;
    logic          peak_enable, hpf_enable, power_down, mod_clk_fast;
    logic [2:0]    gain_left, gain_right;
    logic [1:0]    data_format, word_width, mclk_div;
    logic          slave_mode, mute_right, mute_left, bypass_left, bypass_right;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ctl_serial_port #(.SAMPLE_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sel_n(sel_n), .sdi(sdi), .sdo(sdo),
        .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right),
        .peak_enable(peak_enable), .hpf_enable(hpf_enable), .power_down(power_down),
        .mod_clk_fast(mod_clk_fast), .gain_left(gain_left), .gain_right(gain_right),
        .data_format(data_format), .word_width(word_width), .slave_mode(slave_mode),
        .mute_right(mute_right), .mute_left(mute_left), .mclk_div(mclk_div),
        .bypass_left(bypass_left), .bypass_right(bypass_right)
    );

    function automatic logic [9:0] got0();
        return {peak_enable, hpf_enable, power_down, mod_clk_fast, gain_left, gain_right};
    endfunction
    function automatic logic [6:0] got1();
        return {data_format, word_width, slave_mode, mute_right, mute_left};
    endfunction
    function automatic logic [3:0] got2();
        return {bypass_right, bypass_left, mclk_div};
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected attenuation code computed from the arithmetic rule (R8).
    function automatic int exp_code(input longint v);
        longint mag;
        longint q;
        int     msb;
        int     sub;
        int     code;
        mag = (v < 0) ? -v : v;
        if (mag == 0) return 63;
        if (mag >= (longint'(1) << (SW - 1))) return 0;
        msb = 0;
        for (int i = 0; i < SW; i++) if (mag[i]) msb = i;
        q = (msb >= 7) ? (mag >> (msb - 7)) : (mag << (7 - msb));
        sub = 0;
        for (int k = 1; k <= 5; k++)
            if (real'(q) < 256.0 * (10.0 ** ((-1.0 * k) / 20.0))) sub++;
        code = 6 * (SW - 2 - msb) + sub;
        return (code > 63) ? 63 : code;
    endfunction

    // Drive one serial frame with the given number of rising edges.
    task automatic frame(input logic [15:0] w, input int edges,
                         output logic [9:0] rd, output logic hdr_any);
        rd = '0;
        hdr_any = 1'b0;
        @(negedge clk);
        sel_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < edges; i++) begin
            sclk = 1'b0;
            sdi  = (i < 16) ? w[15-i] : 1'b0;
            repeat (8) @(negedge clk);
            if (i >= 6 && i < 16) rd[15-i] = sdo;
            else if (i < 6) hdr_any = hdr_any | sdo;
            sclk = 1'b1;
            repeat (8) @(negedge clk);
        end
        sclk = 1'b0;
        repeat (8) @(negedge clk);
        sel_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [9:0] d);
        logic [9:0] rd;
        logic       h;
        frame({a, 1'b0, 1'b0, d}, 16, rd, h);
    endtask

    task automatic rdreg(input logic [3:0] a, output logic [9:0] rd, output logic h);
        frame({a, 1'b1, 1'b0, 10'h000}, 16, rd, h);
    endtask

    task automatic push(input longint l, input longint r);
        @(negedge clk);
        smp_left  = SW'(l);
        smp_right = SW'(r);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [9:0] pattern(input int k);
        if (k == 0) return 10'h000;
        if (k == 1) return 10'h3FF;
        if (k < 12) return 10'(1 << (k - 2));
        if (k == 12) return 10'h2AA;
        return 10'h155;
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired before the sequence finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [9:0] rd;
        logic       h;
        longint     mag;
        int         e;
        int         m_list [12] = '{128, 143, 144, 161, 162, 181, 182, 203, 204, 228, 229, 255};
        int         b_list [4]  = '{22, 15, 10, 5};

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset values.
        chk("R1 cfg0", got0(), 0);
        chk("R1 cfg1", got1(), 0);
        chk("R1 cfg2", got2(), 0);
        chk("R1 sdo idle", sdo, 0);
        rdreg(4'd3, rd, h); chk("R1 left peak", rd, 63);
        rdreg(4'd4, rd, h); chk("R1 right peak", rd, 63);

        // R2, R3, R4: field position sweeps.
        for (int k = 0; k < 14; k++) begin
            wr(4'd0, pattern(k));
            chk("R2 cfg0 fields", got0(), pattern(k));
        end
        for (int k = 0; k < 14; k++) begin
            wr(4'd1, pattern(k));
            chk("R3 cfg1 fields", got1(), pattern(k) & 10'h07F);
        end
        for (int k = 0; k < 14; k++) begin
            wr(4'd2, pattern(k));
            chk("R4 cfg2 fields", got2(), pattern(k) & 10'h00F);
        end
        chk("R3 cfg1 kept", got1(), 10'h155 & 10'h07F);

        // R6: frames with 15 or 17 edges are dropped.
        frame({4'd0, 1'b0, 1'b0, 10'h0AA}, 15, rd, h);
        chk("R6 short frame", got0(), 10'h155);
        frame({4'd0, 1'b0, 1'b0, 10'h0AA}, 17, rd, h);
        chk("R6 long frame", got0(), 10'h155);

        // R7: writes to status and unused addresses change nothing.
        wr(4'd3, 10'h2AA);
        wr(4'd5, 10'h2AA);
        wr(4'd15, 10'h0F0);
        chk("R7 cfg0 kept", got0(), 10'h155);
        chk("R7 cfg1 kept", got1(), 10'h055);
        chk("R7 cfg2 kept", got2(), 10'h005);
        rdreg(4'd0, rd, h); chk("R7 read of control address", rd, 0);
        rdreg(4'd3, rd, h); chk("R7 status not written", rd, 63);

        // R8 and R5: code sweep with peak capture on.
        wr(4'd0, 10'h200);
        chk("R2 peak enable set", peak_enable, 1);
        for (int p = 0; p < SW - 1; p++) begin
            mag = longint'(1) << p;
            push(mag, -mag);
            rdreg(4'd3, rd, h); chk("R8 left power of two", rd, exp_code(mag));
            chk("R5 header quiet", h, 0);
            rdreg(4'd4, rd, h); chk("R8 right power of two", rd, exp_code(-mag));
            chk("R5 sdo after frame", sdo, 0);
        end
        for (int bi = 0; bi < 4; bi++) begin
            for (int mi = 0; mi < 12; mi++) begin
                mag = (longint'(m_list[mi]) << b_list[bi]) >> 7;
                push(mag, -mag);
                rdreg(4'd3, rd, h); chk("R8 left mantissa", rd, exp_code(mag));
                rdreg(4'd4, rd, h); chk("R8 right mantissa", rd, exp_code(-mag));
            end
        end
        push(-(longint'(1) << (SW - 1)), 0);
        rdreg(4'd3, rd, h); chk("R8 negative full scale", rd, 0);
        rdreg(4'd4, rd, h); chk("R8 zero sample", rd, 63);
        push((longint'(1) << (SW - 1)) - 1, 1);
        rdreg(4'd3, rd, h); chk("R8 positive max", rd, exp_code((longint'(1) << (SW - 1)) - 1));
        rdreg(4'd4, rd, h); chk("R8 one LSB", rd, 63);

        // R9: the register keeps the loudest of several samples.
        push(longint'(1) << 18, 3);
        push(longint'(5) << 19, 3);
        push(longint'(1) << 12, 3);
        e = exp_code(longint'(5) << 19);
        rdreg(4'd3, rd, h); chk("R9 hold minimum", rd, e);
        rdreg(4'd3, rd, h); chk("R9 read clears", rd, 63);
        rdreg(4'd4, rd, h); chk("R9 right minimum", rd, exp_code(3));

        // R6: an aborted read leaves the peak in place.
        push(longint'(3) << 16, 0);
        frame({4'd3, 1'b1, 1'b0, 10'h000}, 12, rd, h);
        rdreg(4'd3, rd, h); chk("R6 aborted read keeps peak", rd, exp_code(longint'(3) << 16));

        // R10: no capture while the enable is low.
        wr(4'd0, 10'h000);
        push(longint'(1) << 22, -(longint'(1) << 22));
        rdreg(4'd3, rd, h); chk("R10 left not captured", rd, 63);
        rdreg(4'd4, rd, h); chk("R10 right not captured", rd, 63);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule